// File: doc/BRIEF.md
# Autonomous Conversion Scheduler with Min/Max Tracking

This block paces an external analog-to-digital converter without host involvement. A 3-bit cycle-time code selects the mode. A code of zero leaves the converter idle until the host asks for a sample. Any non-zero code n starts a conversion every 2^(n+4) ticks of a prescaled clock. A tick occurs once every `PRESCALE` core clock cycles.

Every finished conversion is stored in a result register. A one-cycle valid strobe marks each update so that a downstream alert comparator can evaluate the new sample. Conversions started by the period timer also update a running minimum and a running maximum. These two registers hold their values until the host writes a clear strobe. Clearing the minimum loads all ones and clearing the maximum loads zero, so the next periodic sample replaces both.

Top module: `conv_sched`

## Requirements
- R1: After reset, `conv_start_o` and `result_valid_o` are 0, `result_o` is 0, `min_o` is all ones and `max_o` is 0.
- R2: With `cycle_code_i` = 0, no conversion starts on its own. A one-cycle `host_req_i` while the converter is idle produces a one-cycle `conv_start_o` on the next cycle.
- R3: With `cycle_code_i` = n (1..7) and a converter that finishes within the period, consecutive `conv_start_o` pulses are exactly 2^(n+4)·`PRESCALE` clock cycles apart.
- R4: A change of `cycle_code_i` restarts the period count, so the first start after the change comes one full new period later, give or take one tick.
- R5: A start is issued only when no conversion is outstanding. A period that expires while one is outstanding is dropped and not queued, which doubles the spacing when the converter is slower than one period. A `host_req_i` during a conversion is ignored.
- R6: On `conv_done_i` for an outstanding conversion, `result_o` takes `conv_data_i` and `result_valid_o` is high for exactly one cycle, at the same edge. This holds in both modes.
- R7: After each conversion started by the period timer, `min_o` takes the result if the result is smaller and `max_o` takes it if the result is larger.
- R8: Conversions started by `host_req_i` update `result_o` but leave `min_o` and `max_o` unchanged.
- R9: A `min_clr_i` pulse sets `min_o` to all ones and a `max_clr_i` pulse sets `max_o` to 0 on the next cycle. Each register otherwise holds its value until a periodic sample beats it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_code_i | input | 3 | 0: host-triggered mode; n>0: period of 2^(n+4) ticks |
| host_req_i | input | 1 | Host conversion request pulse (used when code is 0) |
| conv_done_i | input | 1 | Converter finished; `conv_data_i` is valid |
| conv_data_i | input | DATA_W | Converter sample |
| min_clr_i | input | 1 | Host write strobe: reset minimum to all ones |
| max_clr_i | input | 1 | Host write strobe: reset maximum to zero |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| result_o | output | DATA_W | Latest conversion result |
| min_o | output | DATA_W | Smallest periodic sample since last clear |
| max_o | output | DATA_W | Largest periodic sample since last clear |
| result_valid_o | output | 1 | One-cycle strobe marking a result update |

## Verification
The hardest situation to reach is a period that expires while a conversion is still outstanding. In that case the skipped start must vanish rather than fire once the converter frees up. The bench reaches it with a converter model whose latency is set beyond one period. It then checks that the start spacing doubles exactly. A second hard case is the restart on a code change. The bench changes the code in the middle of a long period and bounds the arrival of the next start against the new period, not the old one.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int unsigned PERIOD_SHIFT = 4;

  function automatic int unsigned period_ticks(input int unsigned code);
    return 32'd1 << (code + PERIOD_SHIFT);
  endfunction
endpackage

// File: rtl/conv_prescaler.sv
module conv_prescaler #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] cnt_q;

  assign tick_o = (cnt_q == PS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_PS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PS_LAST); // R3
endmodule

// File: rtl/conv_period_timer.sv
module conv_period_timer #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fire_o
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last;
  logic              code_chg;
  logic              idle_mode;

  assign code_chg  = (code_i != code_q);
  assign idle_mode = (code_i == '0);
  assign last      = CNT_W'(conv_sched_pkg::period_ticks(int'(code_i)) - 1);
  assign fire_o    = tick_i && !code_chg && !idle_mode && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      code_q <= code_i;
      if (code_chg || idle_mode) cnt_q <= '0;  // restart on any code change
      else if (tick_i)           cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!code_chg && !idle_mode) |-> (cnt_q <= last)); // R3
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_chg |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/conv_extreme_trk.sv
module conv_extreme_trk #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              min_clr_i,
  input  logic              max_clr_i,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o
);
  logic [DATA_W-1:0] ext_w [2];

  for (genvar g = 0; g < 2; g++) begin : g_ch
    localparam bit IS_MAX = (g == 1);
    logic [DATA_W-1:0] q;
    logic              clr;
    logic              beats;

    assign clr   = IS_MAX ? max_clr_i : min_clr_i;
    assign beats = IS_MAX ? (data_i > q) : (data_i < q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             q <= {DATA_W{~IS_MAX}};
      else if (clr)            q <= {DATA_W{~IS_MAX}};
      else if (upd_i && beats) q <= data_i;
    end

    assign ext_w[g] = q;
  end

  assign min_o = ext_w[0];
  assign max_o = ext_w[1];

  AST_MIN_LE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !min_clr_i && !max_clr_i) |=> (min_o <= max_o)); // R7
  AST_MIN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_clr_i |=> (&min_o)); // R9
  AST_MAX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_clr_i |=> (max_o == '0)); // R9
  AST_EXT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !min_clr_i && !max_clr_i) |=> ($stable(min_o) && $stable(max_o))); // R8
endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned PRESCALE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] cycle_code_i,
  input  logic              host_req_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              min_clr_i,
  input  logic              max_clr_i,
  output logic              conv_start_o,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o,
  output logic              result_valid_o
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 1 + conv_sched_pkg::PERIOD_SHIFT;

  logic              tick;
  logic              fire;
  logic              auto_mode;
  logic              busy_q;
  logic              auto_q;   // outstanding conversion came from the timer
  logic              start_d;
  logic              start_q;
  logic              done_ok;
  logic              vld_q;
  logic [DATA_W-1:0] res_q;

  conv_prescaler #(.PRESCALE(PRESCALE)) u_ps (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  conv_period_timer #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .code_i(cycle_code_i),
    .fire_o(fire)
  );

  assign auto_mode = (cycle_code_i != '0);
  // expiry during a conversion is dropped, never queued
  assign start_d   = !busy_q && (auto_mode ? fire : host_req_i);
  assign done_ok   = conv_done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      auto_q  <= 1'b0;
      start_q <= 1'b0;
      vld_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      start_q <= start_d;
      vld_q   <= done_ok;
      if (start_d) begin
        busy_q <= 1'b1;
        auto_q <= auto_mode;
      end else if (done_ok) begin
        busy_q <= 1'b0;
      end
      if (done_ok) res_q <= conv_data_i;
    end
  end

  conv_extreme_trk #(.DATA_W(DATA_W)) u_ext (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (done_ok && auto_q),
    .data_i   (conv_data_i),
    .min_clr_i(min_clr_i),
    .max_clr_i(max_clr_i),
    .min_o    (min_o),
    .max_o    (max_o)
  );

  assign conv_start_o   = start_q;
  assign result_o       = res_q;
  assign result_valid_o = vld_q;

  AST_MANUAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_mode && !host_req_i) |=> !conv_start_o); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R5
  AST_BUSY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !conv_done_i) |=> !conv_start_o); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_ok |=> $stable(result_o)); // R6
endmodule

// File: tb/sim_conv_sched.sv
module sim_conv_sched;
  localparam int DW = 12;
  localparam int PS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    code = '0;
  logic          host_req = 1'b0;
  logic          done = 1'b0;
  logic [DW-1:0] data = '0;
  logic          min_clr = 1'b0;
  logic          max_clr = 1'b0;
  logic          start;
  logic [DW-1:0] result, min_v, max_v;
  logic          valid;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int lat = 3;
  int fi = 0;
  int n_starts = 0;
  int start_t [64];
  logic [DW-1:0] feed [16];

  always #10 clk = ~clk;  // 50 MHz

  conv_sched #(.DATA_W(DW), .CODE_W(3), .PRESCALE(PS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cycle_code_i(code), .host_req_i(host_req),
    .conv_done_i(done), .conv_data_i(data), .min_clr_i(min_clr), .max_clr_i(max_clr),
    .conv_start_o(start), .result_o(result), .min_o(min_v), .max_o(max_v),
    .result_valid_o(valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // start monitor
  always @(negedge clk) if (rst_n && start) begin
    start_t[n_starts & 63] = cyc;
    n_starts++;
  end

  // converter model with result/valid checks (R6)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && start) begin
        logic [DW-1:0] d;
        d = feed[fi & 15];
        fi++;
        repeat (lat) @(negedge clk);
        done = 1'b1;
        data = d;
        @(negedge clk);
        done = 1'b0;
        chk("R6 result", 32'(result), 32'(d));
        chk("R6 valid high", 32'(valid), 1);
        @(negedge clk);
        chk("R6 valid one cycle", 32'(valid), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  task automatic wait_starts(input int n);
    while (n_starts < n) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 start", 32'(start), 0);
    chk("R1 valid", 32'(valid), 0);
    chk("R1 result", 32'(result), 0);
    chk("R1 min", 32'(min_v), 32'hfff);
    chk("R1 max", 32'(max_v), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_manual();
    int base;
    code = 3'd0;
    lat = 3;
    feed[fi & 15] = 12'h050;
    base = n_starts;
    repeat (300) @(negedge clk);
    chk("R2 no autonomous start", 32'(n_starts), 32'(base));
    host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    chk("R2 start after request", 32'(start), 1);
    host_req = 1'b1;  // during conversion
    @(negedge clk);
    host_req = 1'b0;
    chk("R5 request while busy", 32'(start), 0);
    repeat (20) @(negedge clk);
    chk("R5 one start only", 32'(n_starts), 32'(base + 1));
    chk("R8 min untouched", 32'(min_v), 32'hfff);
    chk("R8 max untouched", 32'(max_v), 0);
    chk("R8 result updated", 32'(result), 32'h050);
  endtask

  task automatic t_auto_minmax();
    int base;
    lat = 3;
    feed[(fi + 0) & 15] = 12'h500;
    feed[(fi + 1) & 15] = 12'h300;
    feed[(fi + 2) & 15] = 12'h900;
    feed[(fi + 3) & 15] = 12'h700;
    base = n_starts;
    code = 3'd1;
    wait_starts(base + 4);
    code = 3'd0;
    chk("R3 period code1 a", 32'(start_t[(base + 2) & 63] - start_t[(base + 1) & 63]), 32 * PS);
    chk("R3 period code1 b", 32'(start_t[(base + 3) & 63] - start_t[(base + 2) & 63]), 32 * PS);
    repeat (10) @(negedge clk);
    chk("R7 min", 32'(min_v), 32'h300);
    chk("R7 max", 32'(max_v), 32'h900);
  endtask

  task automatic t_clear();
    int base;
    @(negedge clk);
    min_clr = 1'b1;
    @(negedge clk);
    min_clr = 1'b0;
    chk("R9 min cleared", 32'(min_v), 32'hfff);
    chk("R9 max kept", 32'(max_v), 32'h900);
    feed[fi & 15] = 12'h650;
    base = n_starts;
    code = 3'd1;
    wait_starts(base + 1);
    code = 3'd0;
    repeat (10) @(negedge clk);
    chk("R7 min after clear", 32'(min_v), 32'h650);
    chk("R7 max kept", 32'(max_v), 32'h900);
    max_clr = 1'b1;
    @(negedge clk);
    max_clr = 1'b0;
    chk("R9 max cleared", 32'(max_v), 0);
    feed[fi & 15] = 12'h400;
    base = n_starts;
    code = 3'd1;
    wait_starts(base + 1);
    code = 3'd0;
    repeat (10) @(negedge clk);
    chk("R7 max after clear", 32'(max_v), 32'h400);
    chk("R7 min follows", 32'(min_v), 32'h400);
  endtask

  task automatic t_skip();
    int base;
    lat = 150;
    base = n_starts;
    code = 3'd1;
    wait_starts(base + 3);
    code = 3'd0;
    chk("R5 skipped period a", 32'(start_t[(base + 1) & 63] - start_t[base & 63]), 64 * PS);
    chk("R5 skipped period b", 32'(start_t[(base + 2) & 63] - start_t[(base + 1) & 63]), 64 * PS);
    repeat (200) @(negedge clk);
    lat = 3;
  endtask

  task automatic t_code_change();
    int base, t_chg, dt;
    base = n_starts;
    code = 3'd2;
    wait_starts(base + 2);
    chk("R3 period code2", 32'(start_t[(base + 1) & 63] - start_t[base & 63]), 64 * PS);
    code = 3'd3;
    wait_starts(base + 3);
    repeat (100) @(negedge clk);
    t_chg = cyc;
    code = 3'd1;
    wait_starts(base + 4);
    dt = start_t[(base + 3) & 63] - t_chg;
    n_chk++;
    if (dt < 31 * PS || dt > 32 * PS + 2) begin
      n_fail++;
      $display("FAIL R4 restart act=%0d exp=%0d..%0d", dt, 31 * PS, 32 * PS + 2);
    end
    code = 3'd0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) feed[i] = '0;
    t_reset();
    t_manual();
    t_auto_minmax();
    t_clear();
    t_skip();
    t_code_change();
    finish_run();
  end
endmodule